// File: doc/BRIEF.md
# Eight-bit ALU with flags

This block is the arithmetic and logic core of a small eight-bit datapath. It has no clock and no state. It takes an accumulator operand, a second operand, the current carry flag and a four-bit operation code. In the same cycle it returns the result and a packed flag byte. That flag byte holds sign, zero, a combined parity/overflow bit and carry.

The parity/overflow bit has two meanings. After logic operations it reports even parity of the result. After arithmetic it reports two's-complement overflow. Negate, complement carry and set carry each have their own flag rules. Compare subtracts only to produce flags and hands the accumulator back unchanged. The operand width is a parameter `W` (default 8); at other widths the sign and overflow bits follow bit `W-1`.

Top module: `alu_flags_core`

## Requirements
- R1: The flag byte carries sign at bit 7, zero at bit 6, parity/overflow at bit 2 and carry at bit 0; bits 5, 4, 3 and 1 are always 0.
- R2: Op codes 0 (add), 1 (add with carry), 2 (subtract) and 3 (subtract with borrow) return acc+opnd, acc+opnd+carry_i, acc-opnd and acc-opnd-carry_i, all modulo 2^W.
- R3: For every op code except 4 (compare), sign equals result bit W-1 and zero is set exactly when the result is 0.
- R4: For op codes 0 to 3, carry is the carry out of bit W-1 (addition) or the borrow into it (subtraction), incoming carry included. Parity/overflow is set on signed overflow.
- R5: Op code 4 (compare) returns the accumulator. Sign is bit W-1 of acc-opnd, zero is set when acc equals opnd, carry is set when acc < opnd unsigned, and parity/overflow is the signed overflow of acc-opnd.
- R6: Op codes 5 (AND), 6 (OR) and 7 (XOR) return the bitwise result, set parity/overflow when it has an even number of ones, and clear carry.
- R7: Op code 8 (negate) returns 0-acc. Parity/overflow is set exactly when acc was 2^(W-1) (0x80 at W=8); carry is set exactly when acc was 0.
- R8: Op code 9 (complement carry) returns acc with carry = NOT carry_i. Op code 10 (set carry) returns acc with carry = 1. For both, parity/overflow is the even parity of acc.
- R9: Op codes 11 to 15 return acc, pass carry_i through unchanged, and report the even parity of acc in parity/overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_i | input | W | Accumulator operand |
| opnd_i | input | W | Second operand |
| carry_i | input | 1 | Current carry flag |
| op_i | input | 4 | Operation code |
| result_o | output | W | Result (the accumulator for compare and the carry ops) |
| flags_o | output | 8 | Packed flag byte |

## Verification
The bench builds the block with `W = 4`. This shrinks the operand space to 16 values per operand. The bench can then sweep every op code, including the unused ones, against every accumulator, operand and incoming carry. The sweep reaches every carry, borrow and overflow boundary, the signed minimum for negate, and the zero and equality cases of compare. At 8 bits these are only sampled points.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBC = 4'd3,
    OP_CMP = 4'd4,
    OP_AND = 4'd5,
    OP_OR  = 4'd6,
    OP_XOR = 4'd7,
    OP_NEG = 4'd8,
    OP_CCF = 4'd9,
    OP_SCF = 4'd10
  } alu_op_e;

  localparam int FLAG_BITS = 8;
  localparam int POS_S     = 7;
  localparam int POS_Z     = 6;
  localparam int POS_PV    = 2;
  localparam int POS_C     = 0;

  typedef struct packed {
    logic s;
    logic z;
    logic pv;
    logic c;
  } alu_flags_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         inv_y_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);
  localparam int MSB = W - 1;

  logic [W-1:0] y_eff;
  logic [W:0]   full;

  always_comb begin
    y_eff  = inv_y_i ? ~y_i : y_i;
    full   = {1'b0, x_i} + {1'b0, y_eff} + {{W{1'b0}}, cin_i};
    sum_o  = full[W-1:0];
    cout_o = full[W];
    // signed overflow: like-signed inputs give a differently signed sum
    ovf_o  = (x_i[MSB] == y_eff[MSB]) && (full[MSB] != x_i[MSB]);
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   sel_i,
  output logic [W-1:0] r_o
);
  always_comb begin
    unique case (sel_i)
      2'd1:    r_o = a_i & b_i;
      2'd2:    r_o = a_i | b_i;
      2'd3:    r_o = a_i ^ b_i;
      default: r_o = a_i;
    endcase
  end
endmodule

// File: rtl/alu_flag_pack.sv
module alu_flag_pack
  import alu_flags_pkg::*;
(
  input  alu_flags_t           fl_i,
  output logic [FLAG_BITS-1:0] byte_o
);
  always_comb begin
    byte_o         = '0;
    byte_o[POS_S]  = fl_i.s;
    byte_o[POS_Z]  = fl_i.z;
    byte_o[POS_PV] = fl_i.pv;
    byte_o[POS_C]  = fl_i.c;
  end
endmodule

// File: rtl/alu_flags_core.sv
module alu_flags_core
  import alu_flags_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] opnd_i,
  input  logic         carry_i,
  input  logic [3:0]   op_i,
  output logic [W-1:0] result_o,
  output logic [7:0]   flags_o
);
  localparam int MSB = W - 1;

  alu_op_e    op;
  logic [W-1:0] add_x, add_y, add_sum, log_r;
  logic         add_inv, add_cin, add_cout, add_ovf;
  logic [1:0]   log_sel;
  alu_flags_t   fl;

  assign op = alu_op_e'(op_i);

  // operand steering for the shared adder
  always_comb begin
    add_x   = acc_i;
    add_y   = opnd_i;
    add_inv = 1'b0;
    add_cin = 1'b0;
    unique case (op)
      OP_ADC: add_cin = carry_i;
      OP_SUB, OP_CMP: begin
        add_inv = 1'b1;
        add_cin = 1'b1;
      end
      OP_SBC: begin
        add_inv = 1'b1;
        add_cin = ~carry_i;
      end
      OP_NEG: begin
        add_x   = '0;
        add_y   = acc_i;
        add_inv = 1'b1;
        add_cin = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    unique case (op)
      OP_AND:  log_sel = 2'd1;
      OP_OR:   log_sel = 2'd2;
      OP_XOR:  log_sel = 2'd3;
      default: log_sel = 2'd0;
    endcase
  end

  alu_addsub #(.W(W)) u_addsub (
    .x_i    (add_x),
    .y_i    (add_y),
    .inv_y_i(add_inv),
    .cin_i  (add_cin),
    .sum_o  (add_sum),
    .cout_o (add_cout),
    .ovf_o  (add_ovf)
  );

  alu_logic #(.W(W)) u_logic (
    .a_i  (acc_i),
    .b_i  (opnd_i),
    .sel_i(log_sel),
    .r_o  (log_r)
  );

  // result and flag selection
  always_comb begin
    result_o = acc_i;
    fl.pv    = ~^acc_i;
    fl.c     = carry_i;
    unique case (op)
      OP_ADD, OP_ADC: begin
        result_o = add_sum;
        fl.pv    = add_ovf;
        fl.c     = add_cout;
      end
      OP_SUB, OP_SBC: begin
        result_o = add_sum;
        fl.pv    = add_ovf;
        fl.c     = ~add_cout;
      end
      OP_CMP: begin
        fl.pv = add_ovf;
        fl.c  = ~add_cout;
      end
      OP_AND, OP_OR, OP_XOR: begin
        result_o = log_r;
        fl.pv    = ~^log_r;
        fl.c     = 1'b0;
      end
      OP_NEG: begin
        result_o = add_sum;
        fl.pv    = add_ovf;
        fl.c     = add_cout;
      end
      OP_CCF: fl.c = ~carry_i;
      OP_SCF: fl.c = 1'b1;
      default: ;
    endcase
    if (op == OP_CMP) begin
      fl.s = add_sum[MSB];
      fl.z = (add_sum == '0);
    end else begin
      fl.s = result_o[MSB];
      fl.z = (result_o == '0);
    end
  end

  alu_flag_pack u_pack (
    .fl_i  (fl),
    .byte_o(flags_o)
  );
endmodule

// File: rtl/alu_flags_chk.sv
module alu_flags_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] acc_i,
  input logic [W-1:0] opnd_i,
  input logic         carry_i,
  input logic [3:0]   op_i,
  input logic [W-1:0] result_o,
  input logic [7:0]   flags_o
);
  always_comb begin
    if (!$isunknown({acc_i, opnd_i, carry_i, op_i})) begin
      p_reserved_zero_r1: assert ((flags_o & 8'h3A) == 8'h00);
      if (op_i != 4'd4) begin
        p_sign_follows_r3: assert (flags_o[7] == result_o[W-1]);
        p_zero_follows_r3: assert (flags_o[6] == (result_o == '0));
      end
      if (op_i == 4'd4) begin
        p_cmp_keeps_acc_r5: assert (result_o == acc_i);
        p_cmp_zero_eq_r5:   assert (flags_o[6] == (acc_i == opnd_i));
        p_cmp_carry_lt_r5:  assert (flags_o[0] == (acc_i < opnd_i));
      end
      if (op_i >= 4'd5 && op_i <= 4'd7) begin
        p_logic_no_carry_r6: assert (flags_o[0] == 1'b0);
        p_logic_parity_r6:   assert (flags_o[2] == ~^result_o);
      end
      if (op_i == 4'd9) begin
        p_ccf_flip_r8: assert (flags_o[0] == !carry_i && result_o == acc_i);
      end
      if (op_i == 4'd10) begin
        p_scf_set_r8: assert (flags_o[0] && result_o == acc_i);
      end
      if (op_i >= 4'd11) begin
        p_unused_pass_r9: assert (result_o == acc_i && flags_o[0] == carry_i);
      end
    end
  end
endmodule

bind alu_flags_core alu_flags_chk #(.W(W)) u_alu_flags_chk (
  .acc_i   (acc_i),
  .opnd_i  (opnd_i),
  .carry_i (carry_i),
  .op_i    (op_i),
  .result_o(result_o),
  .flags_o (flags_o)
);

// File: tb/test_alu_flags_core.sv
module test_alu_flags_core;
  localparam int W   = 4;
  localparam int MSK = (1 << W) - 1;
  localparam int MIN = 1 << (W - 1);

  logic         clk = 1'b0;
  logic [W-1:0] acc, opnd, res;
  logic         cin;
  logic [3:0]   op;
  logic [7:0]   flg;
  int           checks = 0;
  int           errors = 0;
  bit           done   = 0;

  always #2.5 clk = ~clk;

  alu_flags_core #(.W(W)) i_alu_flags_core (
    .acc_i   (acc),
    .opnd_i  (opnd),
    .carry_i (cin),
    .op_i    (op),
    .result_o(res),
    .flags_o (flg)
  );

  function automatic bit even_par(int v);
    int n = 0;
    for (int i = 0; i < W; i++) n += (v >> i) & 1;
    return (n % 2) == 0;
  endfunction

  function automatic string tag_of(int o);
    case (o)
      0, 1, 2, 3: return "R2/R4";
      4:          return "R5";
      5, 6, 7:    return "R6";
      8:          return "R7";
      9, 10:      return "R8";
      default:    return "R9";
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s op=%0d a=%0d b=%0d c=%0d actual=%h expected=%h",
               tag, op, acc, opnd, cin, act, exp);
    end
  endtask

  task automatic run_one(int o, int a, int b, int c);
    int r, t, s, z, p, cy;
    r = a; p = even_par(a); cy = c; t = 0;
    case (o)
      0, 1: begin  // R2 R4 addition
        t  = a + b + ((o == 1) ? c : 0);
        r  = t & MSK;
        cy = (t > MSK);
        p  = (((a ^ r) & (b ^ r) & MIN) != 0);
      end
      2, 3, 4: begin  // R2 R4 R5 subtraction and compare
        t  = a - b - ((o == 3) ? c : 0);
        r  = t & MSK;
        cy = (t < 0);
        p  = (((a ^ b) & (a ^ r) & MIN) != 0);
      end
      5: begin r = a & b; p = even_par(r); cy = 0; end  // R6
      6: begin r = a | b; p = even_par(r); cy = 0; end
      7: begin r = a ^ b; p = even_par(r); cy = 0; end
      8: begin r = (-a) & MSK; p = (a == MIN); cy = (a == 0); end  // R7
      9:  cy = !c;  // R8
      10: cy = 1;
      default: ;    // R9
    endcase
    if (o == 4) begin
      s = ((r & MIN) != 0);
      z = (a == b);
      r = a;
    end else begin
      s = ((r & MIN) != 0);
      z = (r == 0);
    end
    op = o[3:0]; acc = a[W-1:0]; opnd = b[W-1:0]; cin = c[0];
    #2;
    check(tag_of(o), int'(res), r);
    check(tag_of(o), int'(flg), (s << 7) | (z << 6) | (p << 2) | cy);
    check("R1", int'(flg & 8'h3A), 0);
    if (o != 4) check("R3", int'(flg[7:6]), int'({res[W-1], res == '0}));
    #1;
  endtask

  initial begin
    op = '0; acc = '0; opnd = '0; cin = 1'b0;
    #1;
    for (int o = 0; o < 16; o++)
      for (int a = 0; a <= MSK; a++)
        for (int b = 0; b <= MSK; b++)
          for (int c = 0; c < 2; c++)
            run_one(o, a, b, c);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule